// File: doc/BRIEF.md
# Suspend and Wake Sequencer

This block steps a logic fabric into and out of a low-power suspend state when an external request pin is raised or dropped. It owns four control outputs: a fabric-awake status flag, a write lock that freezes every clocked storage element, an output override that forces the pins into their parked behaviour, and an input/interconnect disable. Power gating, pad analog behaviour and clock-manager relock are outside this block. It only orders and times these control signals, all in cycles of a single wake clock.

The request passes through an optional glitch filter, which accepts it only after it has stayed high for `FILT_LEN` consecutive samples. Entry always runs in one fixed order: lock, override, input disable, then the awake flag drops. Consecutive steps are spaced by `STEP_GAP` cycles. Exit re-enables inputs, waits `WAKE_DLY` cycles, then raises the awake flag. The write lock and the output override are then released separately, after two run-time cycle counts. If the request returns before the exit has finished, the sequencer restarts the whole entry order.

States: `ST_RUN` (awake), `ST_LOCK`, `ST_OVR`, `ST_QUIET`, `ST_SLEEP`, `ST_WAKE`, `ST_RELEASE`. Transitions:
- RUN→LOCK on a qualified request.
- LOCK→OVR→QUIET→SLEEP, each after `STEP_GAP` cycles.
- SLEEP→WAKE when the request drops.
- WAKE→RELEASE after `WAKE_DLY` cycles.
- RELEASE→RUN when both release counts are done.
- WAKE→LOCK and RELEASE→LOCK (abort) when the request returns.

Top module: `suspend_seq`

## Requirements
- R1: After reset, `awake`=1 and `wr_lock`, `out_ovr` and `in_dis` are all 0.
- R2: With `filt_en`=0, `wr_lock` rises on the second clock edge after the first edge that samples `suspend` high.
- R3: With `filt_en`=1, entry begins only after `suspend` has been sampled high on `FILT_LEN` consecutive edges, so `wr_lock` rises `FILT_LEN-1` cycles later than in R2. A shorter pulse leaves all four outputs unchanged.
- R4: During entry, `out_ovr` rises `STEP_GAP` edges after `wr_lock` and `in_dis` rises `2*STEP_GAP` edges after it. `awake` falls `3*STEP_GAP` edges after it.
- R5: During exit, `in_dis` falls on the second edge after the first edge that samples `suspend` low. `awake` rises `WAKE_DLY` edges after that.
- R6: `wr_lock` falls max(`cfg_wlock_cyc`,1) edges after `awake` rises.
- R7: `out_ovr` falls max(`cfg_ovr_cyc`,1) edges after `awake` rises, independently of R6.
- R8: A request that returns while in WAKE or RELEASE aborts the exit. `wr_lock` is (re)asserted on the next edge, and the entry steps of R4 are then timed from that edge.
- R9: A request that drops during entry does not stop it. Entry completes, and `in_dis` falls one edge after `awake` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wake clock |
| rst_n | input | 1 | Active-low synchronous reset |
| suspend | input | 1 | Suspend request, already synchronous |
| filt_en | input | 1 | Enables the request glitch filter |
| cfg_wlock_cyc | input | CW | Cycles from awake rise to write-lock release |
| cfg_ovr_cyc | input | CW | Cycles from awake rise to output-override release |
| awake | output | 1 | Fabric awake status |
| wr_lock | output | 1 | Write lock on all clocked storage |
| out_ovr | output | 1 | Output pins forced to suspend behaviour |
| in_dis | output | 1 | Inputs and interconnect disabled |

## Verification
Two events can land on the same edge in RELEASE: a returning request (abort) and the release count that clears `wr_lock` or `out_ovr`. The abort must win and the lock must stay or return high. The bench provokes this by raising the request a few cycles after `awake` rises. In one case the write lock has already been released and in the other it is still held. The bench then checks that `wr_lock` is high one edge after the request is registered, and that the fall of `awake` is timed from that edge. A request that returns during WAKE, racing the `WAKE_DLY` expiry, is judged the same way: the bench checks the new `in_dis` rise time and that `awake` never rose.

// File: rtl/susp_pkg.sv
package susp_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_LOCK,
        ST_OVR,
        ST_QUIET,
        ST_SLEEP,
        ST_WAKE,
        ST_RELEASE
    } seq_state_e;
endpackage

// File: rtl/susp_req_filter.sv
module susp_req_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sus_in,
    input  logic filt_en,
    output logic req_q
);
    localparam int FW = $clog2(FILT_LEN + 1);
    localparam logic [FW-1:0] FMAX = FW'(FILT_LEN);

    logic [FW-1:0] run_cnt;
    logic [FW-1:0] run_nxt;
    logic          qual;

    always_comb begin
        run_nxt = '0;
        if (sus_in) begin
            run_nxt = (run_cnt == FMAX) ? FMAX : run_cnt + 1'b1;
        end
        qual = sus_in && (!filt_en || (run_nxt == FMAX));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            req_q   <= 1'b0;
        end else begin
            run_cnt <= run_nxt;
            req_q   <= qual;
        end
    end

    // R3: with filter on, a qualified request needs a full run of high samples
    p_full_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_q) && $past(filt_en)) |-> (run_cnt == FMAX));

    // R5: a low sample always withdraws the request on the next edge
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sus_in |=> !req_q);
endmodule

// File: rtl/susp_step_timer.sv
module susp_step_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          hit
);
    logic [TW-1:0] cnt;

    assign hit = (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!hit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the step counter never runs past the programmed spacing
    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit);
endmodule

// File: rtl/susp_release_ctr.sv
module susp_release_ctr #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cfg_a,
    input  logic [CW-1:0] cfg_b,
    output logic          done_a,
    output logic          done_b
);
    localparam int RW = CW + 1;

    logic [RW-1:0] cnt;
    logic [RW-1:0] nxt;

    always_comb begin
        nxt    = (cnt == '1) ? cnt : cnt + 1'b1;
        done_a = run && (nxt >= {1'b0, cfg_a});
        done_b = run && (nxt >= {1'b0, cfg_b});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= nxt;
        end
    end

    // R6: the release count only grows while the release phase lasts
    p_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt >= $past(cnt)));
endmodule

// File: rtl/suspend_seq.sv
module suspend_seq
    import susp_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int STEP_GAP = 3,
    parameter int WAKE_DLY = 5,
    parameter int CW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          suspend,
    input  logic          filt_en,
    input  logic [CW-1:0] cfg_wlock_cyc,
    input  logic [CW-1:0] cfg_ovr_cyc,
    output logic          awake,
    output logic          wr_lock,
    output logic          out_ovr,
    output logic          in_dis
);
    localparam int TMAX = (STEP_GAP > WAKE_DLY) ? STEP_GAP : WAKE_DLY;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_e    state;
    seq_state_e    nxt;
    logic          req_q;
    logic          tmr_hit;
    logic [TW-1:0] tmr_limit;
    logic          rel_a;
    logic          rel_b;
    logic          moving;

    susp_req_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sus_in  (suspend),
        .filt_en (filt_en),
        .req_q   (req_q)
    );

    assign tmr_limit = (state == ST_WAKE) ? TW'(WAKE_DLY) : TW'(STEP_GAP);
    assign moving    = (nxt != state);

    susp_step_timer #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (moving),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    susp_release_ctr #(.CW(CW)) u_rel (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_RELEASE),
        .cfg_a  (cfg_wlock_cyc),
        .cfg_b  (cfg_ovr_cyc),
        .done_a (rel_a),
        .done_b (rel_b)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     if (req_q) nxt = ST_LOCK;
            ST_LOCK:    if (tmr_hit) nxt = ST_OVR;
            ST_OVR:     if (tmr_hit) nxt = ST_QUIET;
            ST_QUIET:   if (tmr_hit) nxt = ST_SLEEP;
            ST_SLEEP:   if (!req_q) nxt = ST_WAKE;
            ST_WAKE: begin
                if (req_q)        nxt = ST_LOCK;
                else if (tmr_hit) nxt = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (req_q)              nxt = ST_LOCK;
                else if (rel_a && rel_b) nxt = ST_RUN;
            end
            default:    nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awake   <= 1'b1;
            wr_lock <= 1'b0;
            out_ovr <= 1'b0;
            in_dis  <= 1'b0;
        end else if (moving) begin
            case (nxt)
                ST_LOCK:    wr_lock <= 1'b1;
                ST_OVR:     out_ovr <= 1'b1;
                ST_QUIET:   in_dis  <= 1'b1;
                ST_SLEEP:   awake   <= 1'b0;
                ST_WAKE:    in_dis  <= 1'b0;
                ST_RELEASE: awake   <= 1'b1;
                ST_RUN: begin
                    wr_lock <= 1'b0;
                    out_ovr <= 1'b0;
                end
                default: ;
            endcase
        end else if (state == ST_RELEASE) begin
            if (rel_a) wr_lock <= 1'b0;
            if (rel_b) out_ovr <= 1'b0;
        end
    end

    // R4: the override only engages on top of an established write lock
    p_ovr_after_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ovr) |-> (wr_lock && $past(wr_lock)));

    // R4: inputs are cut only once outputs are overridden
    p_quiet_after_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_dis) |-> (out_ovr && wr_lock));

    // R4: awake drops last
    p_awake_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(awake) |-> (in_dis && out_ovr && wr_lock));

    // R5: awake never rises while inputs are still disabled
    p_awake_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake) |-> !in_dis);

    // R6: the write lock is released only once the fabric is awake
    p_wlock_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_lock) |-> awake);

    // R7: the override is released only once the fabric is awake
    p_ovr_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_ovr) |-> awake);

    // R8: a returning request during release re-locks on the next edge
    p_abort_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE && req_q) |=> (wr_lock && state == ST_LOCK));
endmodule

// File: tb/sim_suspend_seq.sv
module sim_suspend_seq;
    localparam int FL = 3;
    localparam int G  = 2;
    localparam int W  = 3;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          suspend = 1'b0;
    logic          filt_en = 1'b0;
    logic [CW-1:0] cfg_wl = 10'd1;
    logic [CW-1:0] cfg_ov = 10'd1;
    logic          awake, wr_lock, out_ovr, in_dis;

    suspend_seq #(.FILT_LEN(FL), .STEP_GAP(G), .WAKE_DLY(W), .CW(CW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .suspend       (suspend),
        .filt_en       (filt_en),
        .cfg_wlock_cyc (cfg_wl),
        .cfg_ovr_cyc   (cfg_ov),
        .awake         (awake),
        .wr_lock       (wr_lock),
        .out_ovr       (out_ovr),
        .in_dis        (in_dis)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int t_wl_r = -1, t_wl_f = -1, t_ov_r = -1, t_ov_f = -1;
    int t_id_r = -1, t_id_f = -1, t_aw_r = -1, t_aw_f = -1;
    logic p_wl = 1'b0, p_ov = 1'b0, p_id = 1'b0, p_aw = 1'b1;
    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    // edge monitor: records the edge number of every output transition
    always @(posedge clk) begin
        cyc = cyc + 1;
        #5;
        if (wr_lock && !p_wl) t_wl_r = cyc;
        if (!wr_lock && p_wl) t_wl_f = cyc;
        if (out_ovr && !p_ov) t_ov_r = cyc;
        if (!out_ovr && p_ov) t_ov_f = cyc;
        if (in_dis && !p_id)  t_id_r = cyc;
        if (!in_dis && p_id)  t_id_f = cyc;
        if (awake && !p_aw)   t_aw_r = cyc;
        if (!awake && p_aw)   t_aw_f = cyc;
        p_wl = wr_lock; p_ov = out_ovr; p_id = in_dis; p_aw = awake;
    end

    function automatic int mx1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_asleep();
        for (int i = 0; i < 3000 && awake; i++) @(negedge clk);
    endtask

    task automatic wait_awake();
        for (int i = 0; i < 3000 && !awake; i++) @(negedge clk);
    endtask

    task automatic wait_released();
        for (int i = 0; i < 3000 && !(awake && !wr_lock && !out_ovr); i++) @(negedge clk);
    endtask

    task automatic do_entry(input bit f);
        int ts;
        string tg;
        tg = f ? "R3 lock rise" : "R2 lock rise";
        @(negedge clk);
        suspend = 1'b1;
        ts = cyc + 1;
        wait_asleep();
        chk(tg, t_wl_r, ts + 1 + (f ? FL - 1 : 0));
        chk("R4 override rise", t_ov_r, t_wl_r + G);
        chk("R4 input disable rise", t_id_r, t_wl_r + 2 * G);
        chk("R4 awake fall", t_aw_f, t_wl_r + 3 * G);
    endtask

    task automatic do_exit(input int cw, input int co);
        int tf;
        @(negedge clk);
        cfg_wl = CW'(cw);
        cfg_ov = CW'(co);
        suspend = 1'b0;
        tf = cyc + 1;
        wait_released();
        chk("R5 input enable", t_id_f, tf + 1);
        chk("R5 awake rise", t_aw_r, tf + 1 + W);
        chk("R6 lock release", t_wl_f, t_aw_r + mx1(cw));
        chk("R7 override release", t_ov_f, t_aw_r + mx1(co));
    endtask

    initial begin
        int ts;
        int old_aw;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 awake", int'(awake), 1);
        chk("R1 wr_lock", int'(wr_lock), 0);
        chk("R1 out_ovr", int'(out_ovr), 0);
        chk("R1 in_dis", int'(in_dis), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2, R4..R7: sweep of both release counts, filter bypassed
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                do_entry(1'b0);
                do_exit(a, b);
            end
        end
        do_entry(1'b0);
        do_exit(512, 1);
        do_entry(1'b0);
        do_exit(1, 512);

        // R3: pulses shorter than the filter length are ignored
        filt_en = 1'b1;
        for (int len = 1; len < FL; len++) begin
            @(negedge clk);
            suspend = 1'b1;
            repeat (len) @(negedge clk);
            suspend = 1'b0;
            repeat (12) @(negedge clk);
            chk("R3 short pulse awake", int'(awake), 1);
            chk("R3 short pulse wr_lock", int'(wr_lock), 0);
            chk("R3 short pulse out_ovr", int'(out_ovr), 0);
            chk("R3 short pulse in_dis", int'(in_dis), 0);
        end
        do_entry(1'b1);
        do_exit(2, 3);
        filt_en = 1'b0;

        // R9: one-cycle request still completes the entry
        cfg_wl = 10'd1;
        cfg_ov = 10'd1;
        @(negedge clk);
        suspend = 1'b1;
        ts = cyc + 1;
        @(negedge clk);
        suspend = 1'b0;
        wait_asleep();
        wait_released();
        chk("R9 lock rise", t_wl_r, ts + 1);
        chk("R9 awake fall", t_aw_f, ts + 1 + 3 * G);
        chk("R9 exit start", t_id_f, t_aw_f + 1);

        // R8: abort while both locks still held
        do_entry(1'b0);
        @(negedge clk);
        cfg_wl = 10'd512;
        cfg_ov = 10'd512;
        suspend = 1'b0;
        wait_awake();
        repeat (3) @(negedge clk);
        suspend = 1'b1;
        ts = cyc + 1;
        wait_asleep();
        chk("R8 abort awake fall", t_aw_f, ts + 1 + 3 * G);
        chk("R8 abort lock held", int'(wr_lock), 1);
        chk("R8 abort in_dis rise", t_id_r, ts + 1 + 2 * G);
        do_exit(1, 1);

        // R8: abort after the write lock was released, override still held
        do_entry(1'b0);
        @(negedge clk);
        cfg_wl = 10'd1;
        cfg_ov = 10'd512;
        suspend = 1'b0;
        wait_awake();
        repeat (3) @(negedge clk);
        chk("R6 early lock release", int'(wr_lock), 0);
        suspend = 1'b1;
        ts = cyc + 1;
        wait_asleep();
        chk("R8 relock edge", t_wl_r, ts + 1);
        chk("R8 relock awake fall", t_aw_f, ts + 1 + 3 * G);
        chk("R8 relock override held", int'(out_ovr), 1);
        do_exit(0, 2);

        // R8: abort during the wake delay
        do_entry(1'b0);
        old_aw = t_aw_r;
        @(negedge clk);
        cfg_wl = 10'd1;
        cfg_ov = 10'd1;
        suspend = 1'b0;
        ts = cyc + 1;
        repeat (2) @(negedge clk);
        suspend = 1'b1;
        ts = cyc + 1;
        repeat (3 * G + 4) @(negedge clk);
        chk("R8 wake abort in_dis rise", t_id_r, ts + 1 + 2 * G);
        chk("R8 wake abort awake stayed low", t_aw_r, old_aw);
        chk("R8 wake abort awake", int'(awake), 0);
        do_exit(3, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule